// File: doc/BRIEF.md
# Presettable Decade Counter

This block is a four-bit synchronous counter that steps through the decimal digits 0 to 9 on each rising clock edge and wraps from nine back to zero. It can be preset to any four-bit value through an active-low load strobe, and it can be cleared to zero by an active-low clear whose timing is fixed at build time: it acts either at once, without waiting for the clock, or only at the next rising edge.

Two count enables must both be high for the digit to advance. The second enable, the chain enable, also gates the terminal-count output, which is high while the digit is nine and the chain enable is high. Several counters form a multi-digit decimal counter when each stage's chain enable comes from the previous stage's terminal-count output and all stages share the clock and the first enable. A preset code outside 0 to 9 rejoins the decimal cycle within two counting edges. All pins are plain control and status signals with no handshake.

Top module: `decade_counter`

## Requirements
- R1: With load_n, cnt_en and chain_en all high, each rising edge advances the digit 0→1→…→9 and then from 9 to 0.
- R2: With ASYNC_CLEAR=1, clear_n low forces the digit to 0000 at once, before any clock edge, and holds it there while low.
- R3: With ASYNC_CLEAR=0, clear_n low leaves the digit unchanged until the next rising edge, which sets it to 0000.
- R4: A rising edge with load_n low (clear_n high) copies preset into the digit, preset[0] being the least significant bit, whatever the enables are; no counting takes place on that edge.
- R5: Clear takes priority over load in both clear modes: an edge with clear_n and load_n both low leaves the digit at 0000.
- R6: With load_n high and either cnt_en or chain_en low, the digit keeps its value across the edge.
- R7: carry_out is high exactly when chain_en is high and the digit equals 9 (binary 1001); it follows chain_en without waiting for a clock edge.
- R8: While counting, codes outside the decimal range step as 10→11→6, 12→13→4 and 14→15→2, so every code is back in 0 to 9 after at most two counting edges.
- R9: Two stages, the upper one's chain_en driven by the lower one's carry_out and cnt_en shared, count together from 00 to 99 and then wrap to 00, the upper carry_out being high at 99.
- R10: cnt_en has no influence on carry_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes except an immediate clear happen on its rising edge |
| clear_n | input | 1 | Active-low clear to zero; immediate or edge-timed per ASYNC_CLEAR |
| load_n | input | 1 | Active-low preset strobe, sampled on the rising edge |
| cnt_en | input | 1 | Count enable that affects counting only |
| chain_en | input | 1 | Count enable that also gates carry_out |
| preset | input | 4 | Value copied into the digit by a load |
| digit | output | 4 | Current counter value, bit 0 least significant |
| carry_out | output | 1 | Terminal-count flag: chain_en high and digit equal to 9 |

## Verification
A vector table drives load, count and hold patterns so that a hold caused by cnt_en can be told from one caused by chain_en, since only the latter drops carry_out at nine. Every non-decimal code is loaded and counted twice, which separates the correct fall-back path from a design that merely wraps at fifteen or jumps straight to zero. Directed tests pull the clear low between edges on an immediate-clear and an edge-clear instance at once, which tells the two clear timings apart and shows a pending load losing to clear. A two-stage chain counted through all hundred values checks that the upper digit moves only on the lower stage's nine.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t TOP_DIGIT = digit_t'(9);

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } op_e;

  // Successor of a digit while counting; codes above nine fall back into the cycle.
  function automatic digit_t step_digit(input digit_t v);
    case (v)
      TOP_DIGIT:       return '0;
      digit_t'(11):    return digit_t'(6);
      digit_t'(13):    return digit_t'(4);
      digit_t'(15):    return digit_t'(2);
      default:         return v + digit_t'(1);
    endcase
  endfunction
endpackage

// File: rtl/dec_next.sv
module dec_next
  import dec_pkg::*;
(
  input  logic   load_n,
  input  logic   cnt_en,
  input  logic   chain_en,
  input  digit_t preset,
  input  digit_t cur,
  output digit_t nxt
);
  op_e op;

  // Load outranks counting; counting needs both enables.
  always_comb begin
    if (!load_n)                 op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_COUNT;
    else                         op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_LOAD:  nxt = preset;
      OP_COUNT: nxt = step_digit(cur);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/dec_state_reg.sv
module dec_state_reg
  import dec_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic   clk,
  input  logic   clear_n,
  input  digit_t nxt,
  output digit_t q
);
  generate
    if (ASYNC_CLEAR) begin : g_async_clear
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= nxt;
      end
    end else begin : g_sync_clear
      always_ff @(posedge clk) begin
        if (!clear_n) q <= '0;
        else          q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/dec_carry.sv
module dec_carry
  import dec_pkg::*;
(
  input  digit_t cur,
  input  logic   chain_en,
  output logic   carry
);
  // Combinational look-ahead flag, no register stage.
  assign carry = chain_en && (cur == TOP_DIGIT);
endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import dec_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic               clk,
  input  logic               clear_n,
  input  logic               load_n,
  input  logic               cnt_en,
  input  logic               chain_en,
  input  logic [DIGIT_W-1:0] preset,
  output logic [DIGIT_W-1:0] digit,
  output logic               carry_out
);
  digit_t nxt_digit;
  digit_t cur_digit;

  dec_next u_next (
    .load_n  (load_n),
    .cnt_en  (cnt_en),
    .chain_en(chain_en),
    .preset  (preset),
    .cur     (cur_digit),
    .nxt     (nxt_digit)
  );

  dec_state_reg #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
    .clk    (clk),
    .clear_n(clear_n),
    .nxt    (nxt_digit),
    .q      (cur_digit)
  );

  dec_carry u_carry (
    .cur     (cur_digit),
    .chain_en(chain_en),
    .carry   (carry_out)
  );

  assign digit = cur_digit;

  // R1: nine wraps to zero when counting
  p_wrap_r1: assert property (@(posedge clk) disable iff (!clear_n)
    (clear_n && load_n && cnt_en && chain_en && digit == TOP_DIGIT) |=> (digit == '0));

  // R4: load captures the preset
  p_load_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (clear_n && !load_n) |=> (digit == $past(preset)));

  // R6: a dropped enable holds the digit
  p_hold_r6: assert property (@(posedge clk) disable iff (!clear_n)
    (clear_n && load_n && !(cnt_en && chain_en)) |=> $stable(digit));

  // R7: carry only at nine, never without chain enable
  p_carry_nine_r7: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out |-> (digit == TOP_DIGIT));
  p_carry_gate_r7: assert property (@(posedge clk) disable iff (!clear_n)
    !chain_en |-> !carry_out);

  // R8: fifteen falls back to two
  p_fallback_r8: assert property (@(posedge clk) disable iff (!clear_n)
    (clear_n && load_n && cnt_en && chain_en && digit == digit_t'(15)) |=> (digit == digit_t'(2)));
endmodule

// File: tb/decade_counter_test.sv
`timescale 1ns/1ps
module decade_counter_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr_a = 1'b0, clr_s = 1'b0;
  logic       load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] dig_lo, dig_hi, dig_s;
  logic       cy_lo, cy_hi, cy_s;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  decade_counter #(.ASYNC_CLEAR(1'b1)) uut (
    .clk(clk), .clear_n(clr_a), .load_n(load_n), .cnt_en(en_p), .chain_en(en_t),
    .preset(preset), .digit(dig_lo), .carry_out(cy_lo));

  decade_counter #(.ASYNC_CLEAR(1'b1)) uut_hi (
    .clk(clk), .clear_n(clr_a), .load_n(load_n), .cnt_en(en_p), .chain_en(cy_lo),
    .preset(preset), .digit(dig_hi), .carry_out(cy_hi));

  decade_counter #(.ASYNC_CLEAR(1'b0)) uut_sync (
    .clk(clk), .clear_n(clr_s), .load_n(load_n), .cnt_en(en_p), .chain_en(en_t),
    .preset(preset), .digit(dig_s), .carry_out(cy_s));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // {clear_n, load_n, en_p, en_t, preset, expected digit, expected carry}
  localparam int NV = 22;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b1,4'd7 ,4'd7 ,1'b0},  // R4 load 7
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd8 ,1'b0},  // R1
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd9 ,1'b1},  // R1 R7
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd0 ,1'b0},  // R1 wrap
    {1'b1,1'b1,1'b0,1'b1,4'd0 ,4'd0 ,1'b0},  // R6 cnt_en low
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd1 ,1'b0},  // R1
    {1'b1,1'b0,1'b1,1'b1,4'd9 ,4'd9 ,1'b1},  // R4
    {1'b1,1'b1,1'b0,1'b1,4'd0 ,4'd9 ,1'b1},  // R10 carry despite cnt_en low
    {1'b1,1'b1,1'b1,1'b0,4'd0 ,4'd9 ,1'b0},  // R6 R7 chain_en low
    {1'b1,1'b0,1'b0,1'b0,4'd10,4'd10,1'b0},  // R4 load ignores enables
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd11,1'b0},  // R8
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd6 ,1'b0},  // R8
    {1'b1,1'b0,1'b1,1'b1,4'd12,4'd12,1'b0},  // R4
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd13,1'b0},  // R8
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd4 ,1'b0},  // R8
    {1'b1,1'b0,1'b1,1'b1,4'd14,4'd14,1'b0},  // R4
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd15,1'b0},  // R8
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd2 ,1'b0},  // R8
    {1'b1,1'b0,1'b1,1'b1,4'd15,4'd15,1'b0},  // R4
    {1'b1,1'b1,1'b1,1'b1,4'd0 ,4'd2 ,1'b0},  // R8
    {1'b0,1'b0,1'b1,1'b1,4'd5 ,4'd0 ,1'b0},  // R5 clear beats load
    {1'b1,1'b0,1'b0,1'b0,4'd3 ,4'd3 ,1'b0}   // R4 bit order
  };

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset digit", dig_lo, 0);
    chk("R7 reset carry", cy_lo, 0);
    chk("R3 reset sync digit", dig_s, 0);
    @(negedge clk);
    clr_a = 1'b1; clr_s = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clr_a, load_n, en_p, en_t, preset} = VEC[i][12:5];
      @(posedge clk); #1;
      chk($sformatf("vector %0d digit", i), dig_lo, int'(VEC[i][4:1]));
      chk($sformatf("vector %0d carry", i), cy_lo, int'(VEC[i][0]));
    end

    // R2 R3 R5: clear timing on both variants
    @(negedge clk);
    clr_a = 1'b1; load_n = 1'b0; preset = 4'd6; en_p = 1'b0; en_t = 1'b0;
    @(posedge clk); #1;
    chk("R4 load sync inst", dig_s, 6);
    @(negedge clk);
    preset = 4'd8; clr_a = 1'b0; clr_s = 1'b0;
    #1;
    chk("R2 immediate clear", dig_lo, 0);
    chk("R3 no clear before edge", dig_s, 6);
    @(posedge clk); #1;
    chk("R3 R5 sync clear beats load", dig_s, 0);
    chk("R2 async held", dig_lo, 0);

    // R9: two-stage chain 00..99 and wrap
    @(negedge clk);
    clr_a = 1'b1; clr_s = 1'b1; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk); #1;
      chk("R9 chain low digit", dig_lo, (i % 100) % 10);
      chk("R9 chain high digit", dig_hi, (i % 100) / 10);
      if (i == 99) chk("R9 chain carry at 99", cy_hi, 1);
      if (i == 98) chk("R9 no chain carry at 98", cy_hi, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule